// File: doc/BRIEF.md
# Load/Store-Multiple Micro-Op Sequencer

This block sits in an instruction decode path. It takes a single 32-bit block-transfer instruction, either a load-multiple or a store-multiple, and expands it into an ordered series of simple micro-ops. It issues one micro-op per clock on a valid/ready output handshake. The instruction is handed over on its own valid/ready handshake, which is open only while no sequence is in progress.

A sequence starts with a micro-op that copies the base register. Next comes one single-register transfer for each register named in the 16-bit list. Each transfer carries the register index, a byte offset and the direction in which that offset is applied. The sequence can end with a re-encoded add- or subtract-immediate instruction that writes the updated address back to the base register. The final micro-op is flagged. The total length of the sequence is reported from its first micro-op onward. Any mode code the block does not support is consumed, raises an error strobe and produces nothing. Executing the micro-ops, memory access and condition evaluation are handled elsewhere.

Top module: `ldst_multi_seq`

## Requirements
- R1: After reset, and whenever no sequence is pending, `instReady` is 1 and `uopValid` is 0. While a sequence is pending, `instReady` is 0.
- R2: The mode code is instruction bits 24:20 (P,U,S,W,L). The supported codes are 0x01, 0x03, 0x08, 0x09, 0x0B, 0x11, 0x12, 0x18 and 0x19. Any other code is accepted with `badInst`=1 in the accept cycle, and `uopValid` stays 0 afterwards.
- R3: N is the number of set bits in the register list (bits 15:0). While a sequence is issued, `uopCount` equals 1+N, plus 1 when W (bit 21) is set.
- R4: The first micro-op has `uopKind`=0 (base copy), and its `uopWord` is the instruction's bits 31:16 followed by sixteen zero bits.
- R5: One transfer micro-op (`uopKind`=1) is issued per set list bit. The transfers come in ascending register order, and `uopReg` is the bit index.
- R6: The first transfer's `uopOffset` depends on P (bit 24) and U (bit 23). P=0,U=0 gives 4N-4. P=0,U=1 gives 0. P=1,U=0 gives 4N. P=1,U=1 gives 4.
- R7: Each later transfer's offset is the previous one plus 4 when U=1, or minus 4 when U=0. `uopAdd` equals U and `uopLoad` equals L (bit 20).
- R8: When W=1, a final micro-op follows the transfers. It has `uopKind`=2 when U=1 and 3 when U=0. Its `uopWord` keeps bits 31:28 of the instruction, ORs in 0x02400000, puts Rn (bits 19:16) in both bits 19:16 and bits 15:12, and carries 4N in bits 7:0.
- R9: `uopLast` is 1 only on the final micro-op of a sequence. With an empty list, the base copy is final, or the writeback is final when W=1.
- R10: While `uopValid`=1 and `uopReady`=0, every micro-op output holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction offered |
| instReady | output | 1 | Sequencer idle, instruction taken this cycle if offered |
| instWord | input | 32 | Block-transfer instruction |
| badInst | output | 1 | Offered instruction has an unsupported mode code |
| uopValid | output | 1 | Micro-op present |
| uopReady | input | 1 | Consumer takes the micro-op |
| uopKind | output | 2 | 0 base copy, 1 transfer, 2 writeback add, 3 writeback subtract |
| uopWord | output | 32 | Encoded instruction for base copy and writeback, zero for transfers |
| uopReg | output | 4 | Register index of a transfer |
| uopOffset | output | 7 | Byte offset of a transfer |
| uopAdd | output | 1 | Offset direction: 1 add, 0 subtract |
| uopLoad | output | 1 | 1 load, 0 store |
| uopLast | output | 1 | Final micro-op of the sequence |
| uopCount | output | 5 | Length of the current sequence |

## Verification
An accepted instruction registers on the accepting edge, and its base copy is visible in the cycle right after. Each later micro-op appears in the cycle after the edge that consumed its predecessor, and the cycle after the final handshake shows `instReady` again. `badInst` is combinational and is due in the accept cycle itself. The bench therefore drives inputs on the falling edge and samples shortly after it. Its queue model advances only on the handshakes it has just seen, so each comparison falls in the cycle where the result is due, even under random backpressure.

// File: rtl/ldsm_pkg.sv
package ldsm_pkg;

  typedef enum logic [1:0] {
    KIND_BASE   = 2'd0,
    KIND_XFER   = 2'd1,
    KIND_WB_ADD = 2'd2,
    KIND_WB_SUB = 2'd3
  } uopKind_e;

  typedef struct packed {
    logic capture;
    logic step;
  } seqStrobe_t;

  function automatic logic modeSupported(input logic [4:0] code);
    case (code)
      5'h01, 5'h03, 5'h08, 5'h09, 5'h0B,
      5'h11, 5'h12, 5'h18, 5'h19: return 1'b1;
      default:                    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ldsm_ctrl.sv
module ldsm_ctrl
  import ldsm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  logic       modeOk,
  input  logic       wbEn,
  input  logic       wbUp,
  input  logic       remEmpty,
  input  logic       remOne,
  input  logic       uopReady,
  output logic       instReady,
  output logic       badInst,
  output logic       uopValid,
  output logic       uopLast,
  output uopKind_e   uopKind,
  output seqStrobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_BASE, ST_XFER, ST_WB} seqState_e;

  seqState_e state, stateNext, afterList;
  logic accept;

  assign instReady = (state == ST_IDLE);
  assign uopValid  = (state != ST_IDLE);
  assign accept    = instValid && instReady;
  assign badInst   = accept && !modeOk;
  assign afterList = wbEn ? ST_WB : ST_IDLE;

  always_comb begin
    strobe         = '0;
    strobe.capture = accept && modeOk;
    strobe.step    = (state == ST_XFER) && uopReady;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (accept && modeOk) stateNext = ST_BASE;
      ST_BASE: if (uopReady) stateNext = remEmpty ? afterList : ST_XFER;
      ST_XFER: if (uopReady && remOne) stateNext = afterList;
      ST_WB:   if (uopReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    uopKind = KIND_BASE;
    uopLast = 1'b0;
    unique case (state)
      ST_BASE: uopLast = remEmpty && !wbEn;
      ST_XFER: begin
        uopKind = KIND_XFER;
        uopLast = remOne && !wbEn;
      end
      ST_WB: begin
        uopKind = wbUp ? KIND_WB_ADD : KIND_WB_SUB;
        uopLast = 1'b1;
      end
      default: ;
    endcase
  end

  // R4: a supported instruction opens its sequence with the base copy
  a_r4_base_first: assert property (@(posedge clk) disable iff (!rstN)
    instValid && instReady && modeOk |=> uopValid && uopKind == KIND_BASE);

  // R2: an unsupported instruction leaves the output quiet
  a_r2_bad_silent: assert property (@(posedge clk) disable iff (!rstN)
    badInst |=> !uopValid && instReady);

  // R9: consuming the flagged micro-op ends the sequence
  a_r9_last_ends: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && uopReady && uopLast |=> !uopValid && instReady);

endmodule

// File: rtl/ldsm_dpath.sv
module ldsm_dpath
  import ldsm_pkg::*;
#(
  parameter int REG_CNT    = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [31:0]                  instWord,
  input  seqStrobe_t                   strobe,
  input  uopKind_e                     uopKind,
  output logic                         modeOk,
  output logic                         wbEn,
  output logic                         wbUp,
  output logic                         remEmpty,
  output logic                         remOne,
  output logic [31:0]                  uopWord,
  output logic [$clog2(REG_CNT)-1:0]   uopReg,
  output logic [$clog2(WORD_BYTES*REG_CNT+1)-1:0] uopOffset,
  output logic                         uopAdd,
  output logic                         uopLoad,
  output logic [$clog2(REG_CNT+3)-1:0] uopCount
);

  localparam int IDX_W = $clog2(REG_CNT);
  localparam int OFF_W = $clog2(WORD_BYTES*REG_CNT+1);
  localparam int CNT_W = $clog2(REG_CNT+3);
  localparam int IMM_W = 8;
  localparam logic [OFF_W-1:0] STEP = OFF_W'(WORD_BYTES);

  logic [31:0]        instReg;
  logic [REG_CNT-1:0] remList;
  logic [OFF_W-1:0]   offReg;
  logic [CNT_W-1:0]   cntReg;
  logic [CNT_W-1:0]   nReg;

  logic [CNT_W-1:0]   newOnes;
  logic [OFF_W-1:0]   newSpan;
  logic [OFF_W-1:0]   startOff;
  logic [IDX_W-1:0]   lowIdx;
  logic [IMM_W-1:0]   wbImm;
  logic [31:0]        wbWord;

  assign modeOk = modeSupported(instWord[24:20]);

  always_comb begin
    newOnes = '0;
    for (int i = 0; i < REG_CNT; i++) newOnes = newOnes + CNT_W'(instWord[i]);
  end

  assign newSpan = OFF_W'(newOnes) * STEP;

  always_comb begin
    unique case ({instWord[24], instWord[23]})
      2'b00:   startOff = newSpan - STEP;
      2'b01:   startOff = '0;
      2'b10:   startOff = newSpan;
      default: startOff = STEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instReg <= '0;
      remList <= '0;
      offReg  <= '0;
      cntReg  <= '0;
      nReg    <= '0;
    end else if (strobe.capture) begin
      instReg <= instWord;
      remList <= instWord[REG_CNT-1:0];
      offReg  <= startOff;
      nReg    <= newOnes;
      cntReg  <= newOnes + CNT_W'(1) + CNT_W'(instWord[21]);
    end else if (strobe.step) begin
      remList <= remList & (remList - REG_CNT'(1));
      offReg  <= instReg[23] ? offReg + STEP : offReg - STEP;
    end
  end

  always_comb begin
    lowIdx = '0;
    for (int i = REG_CNT - 1; i >= 0; i--) begin
      if (remList[i]) lowIdx = IDX_W'(i);
    end
  end

  assign remEmpty = (remList == '0);
  assign remOne   = !remEmpty && ((remList & (remList - REG_CNT'(1))) == '0);
  assign wbEn     = instReg[21];
  assign wbUp     = instReg[23];

  assign wbImm  = IMM_W'(32'(nReg) * WORD_BYTES);
  assign wbWord = {instReg[31:28], 4'h2, 4'h4, instReg[19:16], instReg[19:16], 4'h0, wbImm};

  always_comb begin
    unique case (uopKind)
      KIND_BASE: uopWord = {instReg[31:16], 16'h0000};
      KIND_XFER: uopWord = '0;
      default:   uopWord = wbWord;
    endcase
  end

  assign uopReg    = lowIdx;
  assign uopOffset = offReg;
  assign uopAdd    = instReg[23];
  assign uopLoad   = instReg[20];
  assign uopCount  = cntReg;

  // R5: each consumed transfer removes exactly one register from the list
  a_r5_one_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> $countones(remList) + 1 == $past($countones(remList)));

  // R7: the offset moves one word per transfer in the U direction
  a_r7_offset_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> offReg == ($past(instReg[23]) ? $past(offReg) + STEP
                                                  : $past(offReg) - STEP));

endmodule

// File: rtl/ldst_multi_seq.sv
module ldst_multi_seq
  import ldsm_pkg::*;
#(
  parameter int REG_CNT    = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    instValid,
  output logic                                    instReady,
  input  logic [31:0]                             instWord,
  output logic                                    badInst,
  output logic                                    uopValid,
  input  logic                                    uopReady,
  output logic [1:0]                              uopKind,
  output logic [31:0]                             uopWord,
  output logic [$clog2(REG_CNT)-1:0]              uopReg,
  output logic [$clog2(WORD_BYTES*REG_CNT+1)-1:0] uopOffset,
  output logic                                    uopAdd,
  output logic                                    uopLoad,
  output logic                                    uopLast,
  output logic [$clog2(REG_CNT+3)-1:0]            uopCount
);

  seqStrobe_t strobe;
  uopKind_e   kindSel;
  logic       modeOk, wbEn, wbUp, remEmpty, remOne;

  ldsm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .modeOk    (modeOk),
    .wbEn      (wbEn),
    .wbUp      (wbUp),
    .remEmpty  (remEmpty),
    .remOne    (remOne),
    .uopReady  (uopReady),
    .instReady (instReady),
    .badInst   (badInst),
    .uopValid  (uopValid),
    .uopLast   (uopLast),
    .uopKind   (kindSel),
    .strobe    (strobe)
  );

  ldsm_dpath #(.REG_CNT(REG_CNT), .WORD_BYTES(WORD_BYTES)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .instWord  (instWord),
    .strobe    (strobe),
    .uopKind   (kindSel),
    .modeOk    (modeOk),
    .wbEn      (wbEn),
    .wbUp      (wbUp),
    .remEmpty  (remEmpty),
    .remOne    (remOne),
    .uopWord   (uopWord),
    .uopReg    (uopReg),
    .uopOffset (uopOffset),
    .uopAdd    (uopAdd),
    .uopLoad   (uopLoad),
    .uopCount  (uopCount)
  );

  assign uopKind = kindSel;

  // R10: a stalled micro-op stays put
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && !uopReady |=> uopValid && $stable(uopKind) && $stable(uopWord)
      && $stable(uopReg) && $stable(uopOffset) && $stable(uopLast) && $stable(uopCount));

  // R3: the length stays fixed across handshakes inside one sequence
  a_r3_count_fixed: assert property (@(posedge clk) disable iff (!rstN)
    uopValid && uopReady && !uopLast |=> $stable(uopCount));

  // R1: no new instruction is taken while a sequence is pending
  a_r1_busy_closed: assert property (@(posedge clk) disable iff (!rstN)
    uopValid |-> !instReady);

endmodule

// File: tb/ldst_multi_seq_test.sv
module ldst_multi_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic        uopReady = 1'b0;
  logic        instReady, badInst, uopValid, uopAdd, uopLoad, uopLast;
  logic [1:0]  uopKind;
  logic [31:0] uopWord;
  logic [3:0]  uopReg;
  logic [6:0]  uopOffset;
  logic [4:0]  uopCount;

  ldst_multi_seq uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instReady(instReady),
    .instWord(instWord), .badInst(badInst), .uopValid(uopValid),
    .uopReady(uopReady), .uopKind(uopKind), .uopWord(uopWord),
    .uopReg(uopReg), .uopOffset(uopOffset), .uopAdd(uopAdd),
    .uopLoad(uopLoad), .uopLast(uopLast), .uopCount(uopCount)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          kind;
    logic [31:0] word;
    int          regIdx;
    int          off;
    bit          add;
    bit          load;
    bit          last;
    int          count;
  } expUop_t;

  expUop_t expQ[$];
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit lastAccept = 0;
  bit readyAll = 1;
  bit stalledPrev = 0;
  logic [46:0] snap;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic bit supported(input logic [4:0] c);
    return c inside {5'h01, 5'h03, 5'h08, 5'h09, 5'h0B, 5'h11, 5'h12, 5'h18, 5'h19};
  endfunction

  task automatic pushModel(input logic [31:0] w);
    int n = $countones(w[15:0]);
    bit up = w[23];
    bit wb = w[21];
    int cnt = 1 + n + (wb ? 1 : 0);
    int off;
    int seen = 0;
    expUop_t e;
    case ({w[24], w[23]})
      2'b00: off = 4 * n - 4;
      2'b01: off = 0;
      2'b10: off = 4 * n;
      default: off = 4;
    endcase
    e = '{kind: 0, word: {w[31:16], 16'h0}, regIdx: 0, off: 0, add: up, load: w[20],
          last: (n == 0 && !wb), count: cnt};
    expQ.push_back(e);
    for (int i = 0; i < 16; i++) begin
      if (w[i]) begin
        seen++;
        e = '{kind: 1, word: 32'h0, regIdx: i, off: off, add: up, load: w[20],
              last: (seen == n && !wb), count: cnt};
        expQ.push_back(e);
        off = up ? off + 4 : off - 4;
      end
    end
    if (wb) begin
      e = '{kind: up ? 2 : 3,
            word: (w & 32'hF000_0000) | 32'h0240_0000 | (32'(w[19:16]) << 16)
                  | (32'(w[19:16]) << 12) | 32'(4 * n),
            regIdx: 0, off: 0, add: up, load: w[20], last: 1, count: cnt};
      expQ.push_back(e);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finishRun();
    end
  end

  always @(negedge clk) begin
    uopReady = readyAll ? 1'b1 : ($urandom_range(0, 3) != 0);
  end

  always @(negedge clk) begin
    expUop_t h;
    #2;
    if (rstN) begin
      // R1: readiness mirrors whether the model holds a pending sequence
      chk(instReady == (expQ.size() == 0), "R1 instReady", 32'(instReady), 32'(expQ.size() == 0));
      chk(uopValid == (expQ.size() != 0), "R1 uopValid", 32'(uopValid), 32'(expQ.size() != 0));
      if (uopValid && expQ.size() != 0) begin
        h = expQ[0];
        if (stalledPrev)
          chk({uopKind, uopWord, uopReg, uopOffset, uopLast} == snap, "R10 held outputs",
              32'({uopKind, uopReg, uopOffset, uopLast}), 32'(snap[14:0]));
        chk(uopCount == 5'(h.count), "R3 count", 32'(uopCount), 32'(h.count));
        chk(uopLast == h.last, "R9 last flag", 32'(uopLast), 32'(h.last));
        if (h.kind == 1) begin
          chk(uopKind == 2'd1, "R5 transfer kind", 32'(uopKind), 32'd1);
          chk(uopReg == 4'(h.regIdx), "R5 register order", 32'(uopReg), 32'(h.regIdx));
          chk(uopOffset == 7'(h.off), "R6 R7 offset", 32'(uopOffset), 32'(h.off & 127));
          chk(uopAdd == h.add, "R7 direction", 32'(uopAdd), 32'(h.add));
          chk(uopLoad == h.load, "R7 load flag", 32'(uopLoad), 32'(h.load));
        end else if (h.kind == 0) begin
          chk(uopKind == 2'd0, "R4 base kind", 32'(uopKind), 32'd0);
          chk(uopWord == h.word, "R4 base word", uopWord, h.word);
        end else begin
          chk(uopKind == 2'(h.kind), "R8 writeback kind", 32'(uopKind), 32'(h.kind));
          chk(uopWord == h.word, "R8 writeback word", uopWord, h.word);
        end
      end
      if (instValid && instReady)
        chk(badInst == !supported(instWord[24:20]), "R2 badInst", 32'(badInst),
            32'(!supported(instWord[24:20])));
      else
        chk(badInst == 1'b0, "R2 badInst idle", 32'(badInst), 32'd0);

      stalledPrev = uopValid && !uopReady;
      snap = {uopKind, uopWord, uopReg, uopOffset, uopLast};
      if (uopValid && uopReady && expQ.size() != 0) void'(expQ.pop_front());
      lastAccept = instValid && instReady;
      if (lastAccept && supported(instWord[24:20])) pushModel(instWord);
    end else begin
      lastAccept = 0;
      stalledPrev = 0;
    end
  end

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    instValid = 1'b1;
    instWord = w;
    do @(negedge clk); while (!lastAccept);
    instValid = 1'b0;
    instWord = $urandom;
  endtask

  function automatic logic [31:0] mk(input logic [4:0] code, input logic [15:0] list);
    return {4'($urandom), 3'b100, code, 4'($urandom), list};
  endfunction

  initial begin
    logic [4:0] codes[9] = '{5'h01, 5'h03, 5'h08, 5'h09, 5'h0B, 5'h11, 5'h12, 5'h18, 5'h19};
    logic [4:0] bad[4] = '{5'h00, 5'h1F, 5'h0A, 5'h13};
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    for (int pass = 0; pass < 2; pass++) begin
      readyAll = (pass == 0);
      for (int c = 0; c < 9; c++) begin
        issue(mk(codes[c], 16'h0000));
        issue(mk(codes[c], 16'hFFFF));
        issue(mk(codes[c], 16'h8001));
        issue(mk(codes[c], 16'h0010));
        for (int r = 0; r < 4; r++) issue(mk(codes[c], 16'($urandom)));
      end
      for (int b = 0; b < 4; b++) issue(mk(bad[b], 16'($urandom)));
    end
    readyAll = 0;
    for (int r = 0; r < 40; r++) issue(mk(codes[$urandom_range(0, 8)], 16'($urandom)));
    issue(mk(bad[0], 16'h00FF));
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule